// File: doc/BRIEF.md
# Packet Concatenating Segmenter

This block sits at one input of a slotted switch fabric and serves a single per-destination queue. Packets arrive as byte counts over a valid/ready handshake. The block glues successive packets together into one internal burst and slices that burst into fixed-size segments, one segment per clock (one time slot). Because the packets in a burst sit back to back, only the final segment of the burst is padded. Padding each packet to a segment boundary on its own usually costs more.

A programmable per-burst packet limit caps how many packets may share one burst. The limit is sampled when a burst opens. A limit of 1 gives plain per-packet padding. For each segment the block outputs a descriptor: a valid strobe, first and last flags, and the pad byte count. It also keeps running totals of pad bytes and of payload bytes carried, so that software outside the block can derive a wastage ratio. Payload storage, the crossbar and the scheduler are not part of this block.

Top module: `segcat_segmenter`

## Requirements
- R1: While a burst is open the block emits exactly one segment descriptor per clock. A descriptor appears on the outputs one clock after the cycle that produced it, and no segment is emitted in the cycle that opens a burst.
- R2: A packet offered while a burst is open and the joined-packet count is below the limit is accepted, and its bytes follow the previous packet with no gap. A burst of B total bytes therefore takes ceil(B/64) segments.
- R3: Every segment except the last of a burst has a pad count of 0. The last segment has a pad count of (64 - B mod 64) mod 64, a value from 0 to 63.
- R4: The 4-bit limit is sampled only when a burst opens, and a value of 0 acts as 1. Once the burst holds that many packets, pkt_ready_o stays low until the burst closes. A change of thresh_i during a burst has no effect on that burst.
- R5: A burst closes in the cycle where its remaining bytes, plus any packet accepted in that same cycle, fit in one segment. A packet that arrives after the close opens a new burst.
- R6: seg_first_o marks the first segment of each burst and seg_last_o marks the last. A burst of one segment has both flags set.
- R7: For each segment, pad_total_o grows by that segment's pad count and fwd_total_o grows by 64 minus that pad count. Both totals hold their value in cycles without a segment.
- R8: After reset no segment is valid, both totals are 0 and pkt_ready_o is high.
- R9: With no burst open, pkt_ready_o is high, and an accepted packet opens a new burst whose packet count starts at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one time slot per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | A packet length is offered |
| pkt_len_i | input | 11 | Packet length in bytes, nonzero |
| pkt_ready_o | output | 1 | The offered packet is accepted this cycle |
| thresh_i | input | 4 | Packet limit per burst, 0 acts as 1 |
| seg_valid_o | output | 1 | A segment descriptor is valid |
| seg_first_o | output | 1 | First segment of a burst |
| seg_last_o | output | 1 | Last segment of a burst |
| seg_pad_o | output | 6 | Pad bytes in this segment |
| pad_total_o | output | 32 | Running pad byte total |
| fwd_total_o | output | 32 | Running payload byte total |

## Verification
Joining a packet and closing a burst can happen in the same cycle. When a short packet is accepted while the burst's remaining bytes are small, the combined bytes fit in one segment, so that segment is also the burst's last. The bench provokes this with a 40-byte packet followed by a 24-byte packet under a limit of 2, which must yield a single segment flagged both first and last with zero pad. It also uses three 40-byte packets, where the join and the close coincide with a pad of 8. The burst counts, pad totals and flag counts are checked against values worked out from the requirements.

// File: rtl/segcat_pkg.sv
package segcat_pkg;
  localparam int unsigned SEG_BYTES_D = 64;
  localparam int unsigned LEN_W_D     = 11;
  localparam int unsigned THR_W_D     = 4;
  localparam int unsigned TOT_W_D     = 32;
endpackage

// File: rtl/segcat_admit.sv
module segcat_admit #(
  parameter int unsigned THR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_valid_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             close_i,
  output logic             active_o,
  output logic             start_o,
  output logic             join_o,
  output logic             ready_o,
  output logic             first_o
);
  logic             active_q, first_q;
  logic [THR_W-1:0] cnt_q, cap_q;
  logic             room;

  assign room     = cnt_q < cap_q;
  assign ready_o  = !active_q || room;
  assign start_o  = pkt_valid_i && !active_q;
  assign join_o   = pkt_valid_i && active_q && room;
  assign active_o = active_q;
  assign first_o  = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      cnt_q    <= '0;
      cap_q    <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      first_q  <= 1'b1;
      cnt_q    <= THR_W'(1);
      cap_q    <= (thr_i == '0) ? THR_W'(1) : thr_i; // limit latched once per burst
    end else if (active_q) begin
      first_q <= 1'b0;
      if (join_o)  cnt_q    <= cnt_q + THR_W'(1);
      if (close_i) active_q <= 1'b0;
    end
  end
endmodule

// File: rtl/segcat_slicer.sv
module segcat_slicer #(
  parameter int unsigned SEG_BYTES = 64,
  parameter int unsigned LEN_W     = 11,
  parameter int unsigned BL_W      = 16,
  parameter int unsigned PAD_W     = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             join_i,
  input  logic             active_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             last_o,
  output logic [PAD_W-1:0] pad_o
);
  localparam logic [BL_W-1:0] SEG_V = BL_W'(SEG_BYTES);

  logic [BL_W-1:0] backlog_q, avail, gap;

  assign avail  = backlog_q + (join_i ? BL_W'(len_i) : '0);
  assign last_o = avail <= SEG_V;
  assign gap    = SEG_V - avail;
  assign pad_o  = last_o ? gap[PAD_W-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       backlog_q <= '0;
    else if (start_i)  backlog_q <= BL_W'(len_i);
    else if (active_i) backlog_q <= last_o ? '0 : avail - SEG_V;
  end
endmodule

// File: rtl/segcat_tally.sv
module segcat_tally #(
  parameter int unsigned SEG_BYTES = 64,
  parameter int unsigned PAD_W     = 6,
  parameter int unsigned TOT_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seg_i,
  input  logic [PAD_W-1:0] pad_i,
  output logic [TOT_W-1:0] pad_tot_o,
  output logic [TOT_W-1:0] fwd_tot_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pad_tot_o <= '0;
      fwd_tot_o <= '0;
    end else if (seg_i) begin
      pad_tot_o <= pad_tot_o + TOT_W'(pad_i);
      fwd_tot_o <= fwd_tot_o + TOT_W'(SEG_BYTES) - TOT_W'(pad_i);
    end
  end
endmodule

// File: rtl/segcat_segmenter.sv
module segcat_segmenter import segcat_pkg::*; #(
  parameter int unsigned SEG_BYTES = SEG_BYTES_D,
  parameter int unsigned LEN_W     = LEN_W_D,
  parameter int unsigned THR_W     = THR_W_D,
  parameter int unsigned TOT_W     = TOT_W_D,
  parameter int unsigned PAD_W     = $clog2(SEG_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pkt_valid_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  output logic             pkt_ready_o,
  input  logic [THR_W-1:0] thresh_i,
  output logic             seg_valid_o,
  output logic             seg_first_o,
  output logic             seg_last_o,
  output logic [PAD_W-1:0] seg_pad_o,
  output logic [TOT_W-1:0] pad_total_o,
  output logic [TOT_W-1:0] fwd_total_o
);
  localparam int unsigned BL_W = LEN_W + THR_W + 1;

  logic             active, start, join_c, first_pend, last_c;
  logic [PAD_W-1:0] pad_c;

  segcat_admit #(.THR_W(THR_W)) u_admit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pkt_valid_i (pkt_valid_i),
    .thr_i       (thresh_i),
    .close_i     (last_c),
    .active_o    (active),
    .start_o     (start),
    .join_o      (join_c),
    .ready_o     (pkt_ready_o),
    .first_o     (first_pend)
  );

  segcat_slicer #(
    .SEG_BYTES (SEG_BYTES),
    .LEN_W     (LEN_W),
    .BL_W      (BL_W),
    .PAD_W     (PAD_W)
  ) u_slicer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .join_i   (join_c),
    .active_i (active),
    .len_i    (pkt_len_i),
    .last_o   (last_c),
    .pad_o    (pad_c)
  );

  segcat_tally #(
    .SEG_BYTES (SEG_BYTES),
    .PAD_W     (PAD_W),
    .TOT_W     (TOT_W)
  ) u_tally (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .seg_i     (active),
    .pad_i     (pad_c),
    .pad_tot_o (pad_total_o),
    .fwd_tot_o (fwd_total_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_valid_o <= 1'b0;
      seg_first_o <= 1'b0;
      seg_last_o  <= 1'b0;
      seg_pad_o   <= '0;
    end else begin
      seg_valid_o <= active;
      seg_first_o <= active && first_pend;
      seg_last_o  <= active && last_c;
      seg_pad_o   <= active ? pad_c : '0;
    end
  end
endmodule

// File: rtl/segcat_checker.sv
module segcat_checker #(
  parameter int unsigned SEG_BYTES = 64,
  parameter int unsigned PAD_W     = 6,
  parameter int unsigned TOT_W     = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             seg_valid_o,
  input logic             seg_first_o,
  input logic             seg_last_o,
  input logic [PAD_W-1:0] seg_pad_o,
  input logic [TOT_W-1:0] pad_total_o,
  input logic [TOT_W-1:0] fwd_total_o
);
  logic in_burst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          in_burst_q <= 1'b0;
    else if (seg_valid_o) in_burst_q <= !seg_last_o;
  end

  p_pad_tail_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !seg_last_o |-> seg_pad_o == '0);

  p_first_open_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && !in_burst_q |-> seg_first_o);

  p_first_mid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o && in_burst_q |-> !seg_first_o);

  p_tot_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seg_valid_o |-> (pad_total_o + fwd_total_o) ==
                    ($past(pad_total_o) + $past(fwd_total_o) + TOT_W'(SEG_BYTES)));

  p_tot_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seg_valid_o |-> $stable(pad_total_o) && $stable(fwd_total_o));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seg_valid_o |-> !seg_first_o && !seg_last_o && seg_pad_o == '0);
endmodule

bind segcat_segmenter segcat_checker #(
  .SEG_BYTES (SEG_BYTES),
  .PAD_W     (PAD_W),
  .TOT_W     (TOT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .seg_valid_o (seg_valid_o),
  .seg_first_o (seg_first_o),
  .seg_last_o  (seg_last_o),
  .seg_pad_o   (seg_pad_o),
  .pad_total_o (pad_total_o),
  .fwd_total_o (fwd_total_o)
);

// File: tb/segcat_segmenter_bench.sv
module segcat_segmenter_bench;
  localparam int NV = 8;
  localparam int NP = 5;

  // limit, packet count, lengths, expected segments / bursts / pad
  localparam int V_THR [NV] = '{1, 2, 0, 3, 15, 4, 2, 5};
  localparam int V_N   [NV] = '{2, 2, 2, 4, 1, 5, 2, 2};
  localparam int V_LEN [NV][NP] = '{
    '{80, 150, 0, 0, 0},
    '{80, 150, 0, 0, 0},
    '{64, 128, 0, 0, 0},
    '{40, 40, 40, 40, 0},
    '{1500, 0, 0, 0, 0},
    '{100, 100, 100, 100, 100},
    '{40, 24, 0, 0, 0},
    '{1500, 1500, 0, 0, 0}};
  localparam int V_SEG [NV] = '{5, 4, 3, 3, 24, 9, 1, 47};
  localparam int V_BST [NV] = '{2, 1, 2, 2, 1, 2, 1, 1};
  localparam int V_PAD [NV] = '{90, 26, 0, 32, 36, 76, 0, 8};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_valid = 1'b0;
  logic [10:0] pkt_len = '0;
  logic        pkt_ready;
  logic [3:0]  thresh = 4'd1;
  logic        seg_valid, seg_first, seg_last;
  logic [5:0]  seg_pad;
  logic [31:0] pad_total, fwd_total;

  int n_chk = 0;
  int n_bad = 0;
  int m_seg = 0, m_first = 0, m_last = 0, m_pad = 0, m_badpad = 0, m_stall = 0;

  always #4 clk = ~clk; // 8 ns period

  segcat_segmenter u_segcat_segmenter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pkt_valid_i (pkt_valid),
    .pkt_len_i   (pkt_len),
    .pkt_ready_o (pkt_ready),
    .thresh_i    (thresh),
    .seg_valid_o (seg_valid),
    .seg_first_o (seg_first),
    .seg_last_o  (seg_last),
    .seg_pad_o   (seg_pad),
    .pad_total_o (pad_total),
    .fwd_total_o (fwd_total)
  );

  always @(negedge clk) begin
    if (seg_valid) begin
      m_seg   <= m_seg + 1;
      m_first <= m_first + (seg_first ? 1 : 0);
      m_last  <= m_last + (seg_last ? 1 : 0);
      m_pad   <= m_pad + int'(seg_pad);
      if (!seg_last && seg_pad != 0) m_badpad <= m_badpad + 1;
    end
    if (pkt_valid && !pkt_ready) m_stall <= m_stall + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int len);
    @(negedge clk);
    pkt_valid = 1'b1;
    pkt_len   = 11'(len);
    #1;
    while (!pkt_ready) @(negedge clk);
    @(posedge clk);
    #1;
    pkt_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int s_seg, s_first, s_last, s_pad, s_fwd, s_ptot, s_stall, sum;
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 seg_valid", int'(seg_valid), 0);
    check("R8 pad_total", int'(pad_total), 0);
    check("R8 fwd_total", int'(fwd_total), 0);
    check("R8 ready", int'(pkt_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle ready", int'(pkt_ready), 1);

    for (int v = 0; v < NV; v++) begin
      s_seg = m_seg; s_first = m_first; s_last = m_last; s_pad = m_pad;
      s_fwd = int'(fwd_total); s_ptot = int'(pad_total);
      thresh = 4'(V_THR[v]);
      sum = 0;
      for (int p = 0; p < V_N[v]; p++) begin
        send(V_LEN[v][p]);
        sum += V_LEN[v][p];
      end
      drain();
      check($sformatf("R2 segs v%0d", v), m_seg - s_seg, V_SEG[v]);
      check($sformatf("R4 R5 bursts v%0d", v), m_first - s_first, V_BST[v]);
      check($sformatf("R6 lasts v%0d", v), m_last - s_last, V_BST[v]);
      check($sformatf("R3 pad v%0d", v), m_pad - s_pad, V_PAD[v]);
      check($sformatf("R7 pad_total v%0d", v), int'(pad_total) - s_ptot, V_PAD[v]);
      check($sformatf("R7 fwd_total v%0d", v), int'(fwd_total) - s_fwd, sum);
    end
    check("R3 pad on non-last", m_badpad, 0);

    // R5 a gap closes the burst; the next packet opens another
    s_first = m_first; s_pad = m_pad;
    thresh = 4'd4;
    send(80);
    repeat (5) @(negedge clk);
    send(50);
    drain();
    check("R5 bursts after gap", m_first - s_first, 2);
    check("R5 pad after gap", m_pad - s_pad, 62);

    // R4 limit reached: ready drops while burst is open
    s_first = m_first; s_stall = m_stall;
    thresh = 4'd2;
    send(200);
    send(200);
    send(200);
    drain();
    check("R4 bursts with limit 2", m_first - s_first, 2);
    check("R4 ready low at limit", int'(m_stall - s_stall > 0), 1);

    // R4 limit change during a burst is ignored
    s_first = m_first; s_seg = m_seg;
    thresh = 4'd3;
    send(100);
    thresh = 4'd1;
    send(100);
    send(100);
    drain();
    check("R4 mid-burst limit change", m_first - s_first, 1);
    check("R1 R2 segs 300B", m_seg - s_seg, 5);

    // R1 quiet when idle
    @(negedge clk);
    check("R1 no segment idle", int'(seg_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule